// File: doc/BRIEF.md
# Time-Slot Receive Tap

This block pulls a bit-serial stream out of one chosen time-slot of a framed line and assembles it into chunks of 8, 16 or 32 bits. Each finished chunk is placed in a read register that a processor can inspect. The chunk passed on to the downstream frame receiver is taken from a write register. That register holds a copy of the read register by default, and the processor can overwrite it to modify the stream before it moves on. This "processing" path adds one chunk of latency. It also guarantees that the power-up contents of both registers never reach the frame receiver.

A bypass mode sends each line chunk straight to the output as soon as it completes. In this mode the register pair and the chunk-ready interrupt keep updating, but only so the processor can watch the stream. The frame position counter runs all the time, whether or not the receiver is enabled. Transparent mode holds off the start of reception until the first bit of the selected slot.

Top module: `slot_rx_tap`

## Requirements
- R1: `cfg_chunk` selects the chunk length. 0 gives 8 slot bits, 1 gives 16, and 2 or 3 give 32. A chunk boundary occurs on the slot bit that completes that count.
- R2: Bits are collected MSB first. The first bit of a chunk lands in bit (length-1) of the chunk. A chunk shorter than 32 bits appears in the low bits, with the upper bits zero.
- R3: Frame bit 0 is the cycle in which `frame_sync` is high, and the position then advances by one each clock. Slot k covers frame bits 8k to 8k+7. Line bits outside the selected slot are ignored.
- R4: After `rx_en` rises, or after reset, in processing mode (`cfg_bypass`=0), the first completed chunk produces no output. The prior contents of the read and write registers are never output.
- R5: One clock after a chunk boundary, the read register (address 0) holds the chunk and the sticky status bit (address 2, bit 0) is set. `irq` equals status AND mask, where the mask is address 3, bit 0. Writing 1 to address 2, bit 0 clears the status.
- R6: The frame position counter runs whether or not `rx_en` is set. Enabling before the selected slot in a frame captures that slot in the same frame.
- R7: With `cfg_transparent`=1, reception starts only at bit 0 of the selected slot. An enable that arrives mid-slot waits for the next frame. With `cfg_transparent`=0, reception starts on the next in-slot bit.
- R8: In processing mode, each boundary outputs the write register (address 1), masked to the chunk length, as a one-cycle `out_valid` pulse. One clock after each boundary, the write register is reloaded from the read register. A processor write made before the next boundary replaces what is output at that boundary.
- R9: In bypass mode, each completed line chunk is output one clock after its boundary, starting with the first chunk. Writes to the write register do not change the output.
- R10: While `rx_en` is 0, no output is produced, and the partial chunk and start state are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | High on frame bit 0 |
| line_bit | input | 1 | Serial line data |
| rx_en | input | 1 | Receiver enable; low acts as receiver reset |
| cfg_slot | input | 2 | Selected slot index |
| cfg_chunk | input | 2 | Chunk length select |
| cfg_bypass | input | 1 | 1 = bypass, 0 = processing |
| cfg_transparent | input | 1 | 1 = slot-aligned start |
| cpu_we | input | 1 | Processor write strobe |
| cpu_addr | input | 2 | 0 read reg, 1 write reg, 2 status, 3 mask |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data (combinational) |
| irq | output | 1 | Chunk-ready interrupt |
| out_valid | output | 1 | Chunk valid toward frame receiver |
| out_data | output | 32 | Chunk data toward frame receiver |

## Verification
Some properties are checked on every cycle. An off-slot bit must leave the bit count untouched. A disabled receiver and an unprimed processing path must both stay silent. Output pulses are single cycles. A write-1 clear must drop the interrupt, and a boundary seen with the mask set must raise it. Other behaviours can only be shown by the bench's scenarios. These are MSB-first chunk values, the one-chunk delay of processing mode, same-frame and next-frame starts, and a processor overwrite reaching the output.

// File: rtl/slot_rx_tap.sv
module slot_rx_tap #(
  parameter int SLOTS     = 4,
  parameter int SLOT_BITS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_sync,
  input  logic                       line_bit,
  input  logic                       rx_en,
  input  logic [$clog2(SLOTS)-1:0]   cfg_slot,
  input  logic [1:0]                 cfg_chunk,
  input  logic                       cfg_bypass,
  input  logic                       cfg_transparent,
  input  logic                       cpu_we,
  input  logic [1:0]                 cpu_addr,
  input  logic [31:0]                cpu_wdata,
  output logic [31:0]                cpu_rdata,
  output logic                       irq,
  output logic                       out_valid,
  output logic [31:0]                out_data
);
  localparam int FB = SLOTS * SLOT_BITS;
  localparam int PW = $clog2(FB);
  localparam int BW = $clog2(SLOT_BITS);

  logic [PW-1:0] pos_q, pos;
  logic          in_slot, slot_head, take, done;
  logic          active_q, primed, copy_q, sts_q, msk_q;
  logic [5:0]    cnt, len;
  logic [31:0]   sh, nxt, rd_q, wr_q, lmask;

  assign pos       = frame_sync ? '0 : pos_q;
  assign in_slot   = (pos[PW-1:BW] == cfg_slot);
  assign slot_head = in_slot && (pos[BW-1:0] == '0);
  assign take      = rx_en && in_slot && (active_q || (cfg_transparent ? slot_head : 1'b1));
  assign len       = (cfg_chunk == 2'd0) ? 6'd8 : (cfg_chunk == 2'd1) ? 6'd16 : 6'd32;
  assign lmask     = (cfg_chunk == 2'd0) ? 32'h0000_00FF :
                     (cfg_chunk == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign nxt       = {sh[30:0], line_bit};
  assign done      = take && (cnt + 6'd1 == len);
  assign irq       = sts_q & msk_q;

  always_comb begin
    case (cpu_addr)
      2'd0:    cpu_rdata = rd_q;
      2'd1:    cpu_rdata = wr_q;
      2'd2:    cpu_rdata = {31'd0, sts_q};
      default: cpu_rdata = {31'd0, msk_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q     <= '0;
      active_q  <= 1'b0;
      primed    <= 1'b0;
      copy_q    <= 1'b0;
      cnt       <= '0;
      sh        <= '0;
      rd_q      <= '0;
      wr_q      <= '0;
      sts_q     <= 1'b0;
      msk_q     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      pos_q <= (pos == PW'(FB - 1)) ? '0 : pos + 1'b1;

      if (!rx_en) begin
        active_q <= 1'b0;
        primed   <= 1'b0;
        cnt      <= '0;
        sh       <= '0;
      end else if (take) begin
        active_q <= 1'b1;
        if (done) begin
          cnt    <= '0;
          sh     <= '0;
          primed <= 1'b1;
        end else begin
          cnt <= cnt + 6'd1;
          sh  <= nxt;
        end
      end

      out_valid <= done && (cfg_bypass || primed);
      copy_q    <= done;
      if (done) begin
        out_data <= cfg_bypass ? nxt : (wr_q & lmask);
        rd_q     <= nxt;
      end

      if (cpu_we && cpu_addr == 2'd1) wr_q <= cpu_wdata;
      else if (copy_q)                wr_q <= rd_q;

      if (done)                                         sts_q <= 1'b1;
      else if (cpu_we && cpu_addr == 2'd2 && cpu_wdata[0]) sts_q <= 1'b0;

      if (cpu_we && cpu_addr == 2'd3) msk_q <= cpu_wdata[0];
    end
  end
endmodule

// File: rtl/slot_rx_tap_chk.sv
module slot_rx_tap_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       cfg_bypass,
  input logic       cpu_we,
  input logic [1:0] cpu_addr,
  input logic       wbit0,
  input logic       in_slot,
  input logic       done,
  input logic       primed,
  input logic       msk_q,
  input logic [5:0] cnt,
  input logic       out_valid,
  input logic       irq
);
  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !out_valid);
  // R4
  first_chunk_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_bypass && !primed) |=> !out_valid);
  // R3
  off_slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !in_slot) |=> $stable(cnt));
  // R5
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == 2'd2 && wbit0 && !done) |=> !irq);
  // R5
  irq_on_chunk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && msk_q && !(cpu_we && cpu_addr == 2'd3)) |=> irq);
  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < 6'd32);
  // R8
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
endmodule

bind slot_rx_tap slot_rx_tap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cfg_bypass(cfg_bypass),
  .cpu_we(cpu_we), .cpu_addr(cpu_addr), .wbit0(cpu_wdata[0]),
  .in_slot(in_slot), .done(done), .primed(primed), .msk_q(msk_q),
  .cnt(cnt), .out_valid(out_valid), .irq(irq)
);

// File: tb/slot_rx_tap_test.sv
module slot_rx_tap_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_sync = 0, line_bit = 0, rx_en = 0;
  logic [1:0] cfg_slot = 0, cfg_chunk = 0;
  logic cfg_bypass = 0, cfg_transparent = 0;
  logic cpu_we = 0;
  logic [1:0] cpu_addr = 0;
  logic [31:0] cpu_wdata = 0, cpu_rdata, out_data;
  logic irq, out_valid;

  int n_chk = 0, n_bad = 0, ncap = 0;
  logic [31:0] cap [0:15];

  always #5 clk = ~clk;

  slot_rx_tap uut (.*);

  always @(negedge clk)
    if (out_valid && ncap < 16) begin
      cap[ncap] = out_data;
      ncap++;
    end

  // [15:14] chunk, [13] bypass, [12] transparent, [11:10] slot, [7:0] seed
  localparam logic [15:0] VEC [6] = '{16'h043C, 16'h58A5, 16'h8C5B,
                                      16'h3081, 16'h6C6E, 16'hA4F0};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      frame_sync = 0; line_bit = 0; cpu_we = 0;
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input int en_at, input int wr_at,
                            input logic [1:0] wa, input logic [31:0] wv);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      frame_sync = (i == 0);
      if (i == en_at) rx_en = 1'b1;
      line_bit = (i / 8 == int'(cfg_slot)) ? b[7 - i % 8] : (i[0] ^ i[2]);
      cpu_we = (i == wr_at);
      cpu_addr = wa;
      cpu_wdata = wv;
    end
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    cpu_addr = a;
    #1 d = cpu_rdata;
  endtask

  task automatic restart(input logic [1:0] ch, input bit byp, input bit trn, input logic [1:0] sl);
    rx_en = 0;
    idle(2);
    cfg_chunk = ch; cfg_bypass = byp; cfg_transparent = trn; cfg_slot = sl;
    ncap = 0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1;
    idle(1);
    // R5 R10 reset state
    check(!out_valid, "R10 reset out_valid", {31'd0, out_valid}, 0);
    check(!irq, "R5 reset irq", {31'd0, irq}, 0);
    rd(2'd2, v); check(v == 0, "R5 reset status", v, 0);
    rd(2'd0, v); check(v == 0, "R5 reset read reg", v, 0);

    // vector table: R1 R2 R3 R4 R6 R8 R9
    for (int k = 0; k < 6; k++) begin
      logic [7:0] bytes [8];
      int nb, nch, nexp;
      logic [31:0] e;
      restart(VEC[k][15:14], VEC[k][13], VEC[k][12], VEC[k][11:10]);
      for (int j = 0; j < 8; j++) bytes[j] = VEC[k][7:0] + 8'(j * 8'h25);
      nb = (VEC[k][15:14] == 0) ? 1 : (VEC[k][15:14] == 1) ? 2 : 4;
      nch = 8 / nb;
      for (int j = 0; j < 8; j++) send_frame(bytes[j], (j == 0) ? 0 : -1, -1, 2'd0, 0);
      idle(3);
      nexp = VEC[k][13] ? nch : nch - 1;
      check(ncap == nexp, "R4 R9 output count", ncap, nexp);
      for (int c = 0; c < nexp && c < ncap; c++) begin
        e = 0;
        for (int m = 0; m < nb; m++) e = {e[23:0], bytes[c * nb + m]};
        check(cap[c] == e, "R1 R2 R8 chunk value", cap[c], e);
      end
    end

    // R7 transparent, enable mid-slot waits a frame
    restart(2'd0, 1, 1, 2'd1);
    send_frame(8'hC3, 11, -1, 0, 0);
    send_frame(8'h96, -1, -1, 0, 0);
    send_frame(8'h4D, -1, -1, 0, 0);
    idle(2);
    check(ncap == 2, "R7 transparent count", ncap, 2);
    check(cap[0] == 32'h96, "R7 transparent first chunk", cap[0], 32'h96);

    // R7 non-transparent, enable mid-slot starts at once
    restart(2'd0, 1, 0, 2'd1);
    send_frame(8'hC3, 11, -1, 0, 0);
    send_frame(8'h96, -1, -1, 0, 0);
    idle(2);
    check(ncap == 1, "R7 immediate count", ncap, 1);
    check(cap[0] == 32'h1C, "R7 immediate chunk", cap[0], 32'h1C);

    // R6 enable in frame before the slot
    restart(2'd0, 1, 1, 2'd2);
    send_frame(8'h7E, 3, -1, 0, 0);
    idle(2);
    check(ncap == 1 && cap[0] == 32'h7E, "R6 same-frame start", cap[0], 32'h7E);

    // R8 processor overwrite is forwarded; R5 register readback and interrupt
    restart(2'd0, 0, 0, 2'd1);
    send_frame(8'hA1, 0, -1, 0, 0);
    idle(2);
    check(ncap == 0, "R4 first chunk withheld", ncap, 0);
    rd(2'd0, v); check(v == 32'hA1, "R5 read reg chunk", v, 32'hA1);
    rd(2'd1, v); check(v == 32'hA1, "R8 write reg default copy", v, 32'hA1);
    rd(2'd2, v); check(v == 1, "R5 status set", v, 1);
    check(!irq, "R5 irq masked", {31'd0, irq}, 0);
    cpu_wr(2'd3, 1); #1;
    check(irq, "R5 irq unmasked", {31'd0, irq}, 1);
    cpu_wr(2'd2, 1); #1;
    check(!irq, "R5 irq cleared", {31'd0, irq}, 0);
    send_frame(8'hB2, -1, 2, 2'd1, 32'h0000_015A);
    send_frame(8'hC4, -1, -1, 0, 0);
    idle(2);
    check(ncap == 2, "R8 count", ncap, 2);
    check(cap[0] == 32'h5A, "R8 overwrite forwarded", cap[0], 32'h5A);
    check(cap[1] == 32'hB2, "R8 default copy forwarded", cap[1], 32'hB2);
    check(irq, "R5 irq on new chunk", {31'd0, irq}, 1);
    cpu_wr(2'd3, 0);

    // R9 bypass ignores write register
    restart(2'd0, 1, 0, 2'd1);
    send_frame(8'h11, 0, -1, 0, 0);
    send_frame(8'h22, -1, 2, 2'd1, 32'h77);
    idle(2);
    check(ncap == 2 && cap[1] == 32'h22, "R9 bypass ignores write", cap[1], 32'h22);
    rd(2'd0, v); check(v == 32'h22, "R9 observation read reg", v, 32'h22);

    // R10 disabled receiver stays silent
    restart(2'd0, 1, 0, 2'd1);
    send_frame(8'h33, -1, -1, 0, 0);
    send_frame(8'h44, -1, -1, 0, 0);
    idle(2);
    check(ncap == 0, "R10 no output while disabled", ncap, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule